// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides an unsigned 32-bit dividend by an unsigned 16-bit divisor. It returns a 16-bit quotient and a 16-bit remainder. It makes one shift, compare and conditional subtract per clock. The dividend's upper word serves as the partial remainder register, and its lower word serves as the quotient register. Each step shifts the pair left as one value. The bit leaving the upper word is kept as a seventeenth bit for the compare. The new quotient bit enters at the lower word's least significant bit, so both results finish in place.

A start pulse loads the operands while the unit is idle. Exactly 16 steps follow, and then a single-cycle done pulse marks the results as valid. When the quotient cannot fit in 16 bits, the unit skips the stepping. This happens when the divisor is not larger than the dividend's upper word, which includes a zero divisor. In that case the unit raises the overflow flag together with an immediate done pulse, and the results are undefined.

Top module: `restoring_divider`

## Requirements
- R1: After reset, busy, done and overflow are all low.
- R2: A start taken while idle without overflow drives busy high from the next cycle. It then produces exactly one done cycle, 16 clock edges after the start edge, as busy falls.
- R3: When the divisor is less than or equal to dividend[31:16] (a zero divisor included), overflow and done rise in the cycle after the start edge, and busy never rises.
- R4: At a done without overflow, quotient equals floor(dividend / divisor) and remainder equals dividend mod divisor. During stepping, the partial remainder stays below the divisor.
- R5: A shifted partial remainder that exactly equals the divisor yields a quotient bit of 1, so an exact division leaves a remainder of 0.
- R6: A start raised while busy is ignored: the division in progress finishes with its own operands and timing.
- R7: Quotient and remainder hold their values from done until the next accepted start.
- R8: Overflow stays high until the next accepted start, and it falls when that start does not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division (taken only while idle) |
| dividend | input | 32 | Unsigned dividend, sampled at an accepted start |
| divisor | input | 16 | Unsigned divisor, sampled at an accepted start |
| busy | output | 1 | Stepping in progress |
| done | output | 1 | One-cycle pulse: results or overflow are valid |
| overflow | output | 1 | Quotient would not fit; held until next accepted start |
| quotient | output | 16 | Quotient |
| remainder | output | 16 | Remainder |

## Verification
The assertions assume that start is a clean synchronous level with no unknown values. They also assume that a start arriving in the same cycle as done is a legal new request, so the done-pulse property only applies when start is low. The stimulus drives start, dividend and divisor on the falling edge. Start is released one cycle after every request, except in the one scenario that deliberately holds a second start while busy. Operands include the exact-equal, zero-divisor and largest non-overflowing cases, so that the partial-remainder bound is exercised at its edges.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_step.sv
// One restoring step on the {partial remainder, quotient} pair.
module div_step #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] part_i,
  input  logic [DW-1:0] low_i,
  input  logic [DW-1:0] dvs_i,
  output logic [DW-1:0] part_o,
  output logic [DW-1:0] low_o
);
  logic [DW:0]   wide;
  logic          take;
  logic [DW-1:0] diff;

  always_comb begin
    wide   = {part_i, low_i[DW-1]};
    take   = wide >= {1'b0, dvs_i};
    diff   = wide[DW-1:0] - dvs_i;
    part_o = take ? diff : wide[DW-1:0];
    low_o  = {low_i[DW-2:0], take};
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic too_big_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o,
  output logic ovf_o
);
  localparam int CW = $clog2(DW + 1);

  div_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          ovf_q, ovf_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    ovf_d  = ovf_q;
    load_o = 1'b0;
    step_o = 1'b0;
    if (st_q == ST_RUN) begin
      step_o = 1'b1;
      cnt_d  = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
    end else if (start_i) begin
      load_o = 1'b1;
      ovf_d  = too_big_i;
      if (too_big_i) begin
        done_d = 1'b1;
      end else begin
        st_d  = ST_RUN;
        cnt_d = CW'(DW);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end

  assign busy_o = (st_q == ST_RUN);
  assign done_o = done_q;
  assign ovf_o  = ovf_q;

  // R2: done lasts a single cycle unless a new start is taken alongside it
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !start_i |=> !done_q);
  // R2: leaving the run state always comes with done
  p_busy_fall_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_q);
  // R3: an overflowing request never steps
  p_no_busy_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> !busy_o);
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2*DW-1:0] dividend,
  input  logic [DW-1:0]   divisor,
  output logic            busy,
  output logic            done,
  output logic            overflow,
  output logic [DW-1:0]   quotient,
  output logic [DW-1:0]   remainder
);
  logic [DW-1:0] t_q, t_d, n_q, n_d, n2_q, n2_d;
  logic [DW-1:0] t_step, n_step;
  logic          load, step, too_big;

  assign too_big = divisor <= dividend[2*DW-1:DW];

  div_ctrl #(.DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .too_big_i (too_big),
    .load_o    (load),
    .step_o    (step),
    .busy_o    (busy),
    .done_o    (done),
    .ovf_o     (overflow)
  );

  div_step #(.DW(DW)) u_step (
    .part_i (t_q),
    .low_i  (n_q),
    .dvs_i  (n2_q),
    .part_o (t_step),
    .low_o  (n_step)
  );

  always_comb begin
    t_d  = t_q;
    n_d  = n_q;
    n2_d = n2_q;
    if (load) begin
      t_d  = dividend[2*DW-1:DW];
      n_d  = dividend[DW-1:0];
      n2_d = divisor;
    end else if (step) begin
      t_d = t_step;
      n_d = n_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q  <= '0;
      n_q  <= '0;
      n2_q <= '0;
    end else if (load || step) begin
      t_q  <= t_d;
      n_q  <= n_d;
      n2_q <= n2_d;
    end
  end

  assign quotient  = n_q;
  assign remainder = t_q;

  // R4: partial remainder is bounded by the divisor while stepping
  p_part_lt_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> t_q < n2_q);
  // R6: a start during stepping leaves the held divisor untouched
  p_div_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(n2_q));
  // R7: results are frozen while idle without a start
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(quotient) && $stable(remainder));
endmodule

// File: tb/sim_restoring_divider.sv
`timescale 1ns/1ps
module sim_restoring_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, overflow;
  logic [15:0] quotient, remainder;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  restoring_divider #(.DW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .overflow(overflow),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue a request and return number of falling edges until done is seen
  task automatic issue(input logic [31:0] dd, input logic [15:0] dv, output int lat);
    @(negedge clk);
    start = 1'b1; dividend = dd; divisor = dv;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_normal(input logic [31:0] dd, input logic [15:0] dv, input string req);
    int lat;
    logic [31:0] q, r;
    q = dd / {16'h0, dv};
    r = dd % {16'h0, dv};
    issue(dd, dv, lat);
    chk(lat == 17, "R2 latency", lat, 17);
    chk(!overflow, "R8 overflow low", overflow, 0);
    chk(quotient == q[15:0], {req, " quotient"}, quotient, q);
    chk(remainder == r[15:0], {req, " remainder"}, remainder, r);
    @(negedge clk);
    chk(!done, "R2 single done", done, 0);
  endtask

  task automatic t_overflow(input logic [31:0] dd, input logic [15:0] dv);
    int lat;
    issue(dd, dv, lat);
    chk(lat == 1, "R3 immediate done", lat, 1);
    chk(overflow, "R3 overflow", overflow, 1);
    chk(!busy, "R3 no busy", busy, 0);
    repeat (3) @(negedge clk);
    chk(overflow, "R8 overflow held", overflow, 1);
    chk(!busy && !done, "R3 stays idle", {busy, done}, 0);
  endtask

  task automatic t_ignore_start;
    int lat;
    @(negedge clk);
    start = 1'b1; dividend = 32'h0001_2345; divisor = 16'h0100;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; dividend = 32'h0000_0007; divisor = 16'h0003;
    @(negedge clk);
    start = 1'b0;
    lat = 6;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 17, "R6 timing kept", lat, 17);
    chk(quotient == 16'h0123, "R6 quotient", quotient, 16'h0123);
    chk(remainder == 16'h0045, "R6 remainder", remainder, 16'h0045);
  endtask

  task automatic t_hold;
    logic [15:0] q0, r0;
    q0 = quotient; r0 = remainder;
    dividend = 32'hDEAD_BEEF; divisor = 16'h1;
    repeat (5) @(negedge clk);
    chk(quotient == q0, "R7 quotient hold", quotient, q0);
    chk(remainder == r0, "R7 remainder hold", remainder, r0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !overflow, "R1 reset state", {busy, done, overflow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !overflow, "R1 after release", {busy, done, overflow}, 0);
    t_normal(32'h0000_0087, 16'h000D, "R4 small");
    t_normal(32'h0000_BC2F, 16'h00EE, "R4 mid");
    t_normal(32'hFFFE_FFFF, 16'hFFFF, "R4 max");
    t_normal(32'h0005_0000, 16'h0006, "R4 just fits");
    t_normal(32'h0000_000D, 16'h000D, "R5 exact");
    t_normal(32'h0000_1A00, 16'h0034, "R5 exact multi");
    t_hold;
    t_overflow(32'h0005_0000, 16'h0005);
    t_normal(32'h1234_5678, 16'h9ABC, "R8 clears");
    t_overflow(32'h0000_1234, 16'h0000);
    t_ignore_start;
    t_hold;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule